// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the register-mapped control and status logic that sits in front of an analog-to-digital converter. Software programs a channel selection, a conversion mode and an interrupt enable through an 8-bit register port, then sets a start bit. The block issues one start pulse per conversion, with a channel number, to the converter. It waits for the converter's done pulse before it issues the next one.

In single mode one conversion runs on the selected channel. In scan mode the channels run in ascending order from 0 up to the selected channel, then wrap back to 0. A scan stops after one pass if auto-stop is enabled; otherwise it repeats until software clears the start bit. A completion flag marks the end of a single conversion or of a full scan pass, and an interrupt follows the flag when enabled. The flag clears only under strict rules: a processor write of 0 after a read that saw it set, or a read of the result by a DMA engine that the interrupt triggered.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset both registers read 0x00, and `irq` and `conv_start` are low.
- R2: Register 0 (`bus_addr`=0) holds flag in bit 7, interrupt enable in bit 6, start in bit 5, clock select in bit 4 and channel select in bits 3:0. Register 1 holds scan mode in bit 0 and auto-stop in bit 1, with bits 7:2 reading 0. Reads are combinational on `bus_rdata`.
- R3: In single mode (bit 0 of register 1 is 0), setting start gives one `conv_start` with `conv_ch` equal to the channel select. Start reads 0 in the cycle after the done pulse, and the flag reads 1 one cycle after that.
- R4: In scan mode the conversions run on channels 0, 1, … up to the channel select, then wrap to 0.
- R5: With scan and auto-stop both set, one pass runs. Start then clears in the cycle after the last done pulse, and the flag sets one cycle later.
- R6: With scan set and auto-stop clear, conversions continue after a pass while start stays 1, and the flag sets at the end of the first pass.
- R7: Writing 0 to start halts the sequence: no further `conv_start` follows.
- R8: Writing 1 to the flag bit has no effect. Writing 0 to it has no effect unless a register 0 read has returned the flag as 1 since the last clear.
- R9: A register 0 read that returns the flag as 1, followed by a write of 0 to bit 7, clears the flag.
- R10: A `res_rd` strobe with `dma_ack` high clears the flag. A `res_rd` strobe without `dma_ack` leaves it unchanged.
- R11: `irq` is high exactly when both the flag and the interrupt enable are 1.
- R12: Writes to register 1 are ignored while start is 1.
- R13: Each `conv_start` is a one-cycle pulse, and no new pulse is issued until the converter's done pulse has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 mode |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| res_rd | input | 1 | Result register read strobe |
| dma_ack | input | 1 | High when the result read is a DMA access triggered by the interrupt |
| conv_start | output | 1 | Start-conversion pulse to the converter |
| conv_ch | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | Conversion-done pulse from the converter |
| irq | output | 1 | Conversion-end interrupt |

## Verification
The assertions check four things on every cycle: `conv_start` never lasts two cycles, an automatic fall of start is always followed by the flag, the mode register holds still while start is 1, and every fall of the flag has a legal clear cause in the cycle before. Other behaviours need the bench's scenarios against a latency-modelled converter: the channel order and wrap in scan mode, the exact timing of the start clear and the flag set, the halt on a write of 0, and the read-before-clear rule.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       res_rd,
  input  logic       dma_ack,
  output logic       conv_start,
  output logic [3:0] conv_ch,
  input  logic       conv_done,
  output logic       irq
);
  logic       flag_q, ie_q, start_q, cks_q;
  logic [3:0] chsel_q, cur_ch_q;
  logic       scan_q, astop_q;
  logic       rd_seen_q, busy_q, set_pend_q;

  logic wr0, wr1, last_ch, done_ok, fin, auto_clr, clr_req;

  assign wr0      = bus_wr & ~bus_addr;
  assign wr1      = bus_wr & bus_addr;
  assign last_ch  = ~scan_q | (cur_ch_q >= chsel_q);
  assign done_ok  = busy_q & conv_done;
  assign fin      = done_ok & last_ch;
  assign auto_clr = fin & (~scan_q | astop_q);
  assign clr_req  = (wr0 & ~bus_wdata[7] & rd_seen_q) | (res_rd & dma_ack);

  assign conv_start = start_q & ~busy_q;
  assign conv_ch    = cur_ch_q;
  assign irq        = flag_q & ie_q;
  assign bus_rdata  = bus_addr ? {6'b0, astop_q, scan_q}
                               : {flag_q, ie_q, start_q, cks_q, chsel_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ie_q, cks_q, chsel_q} <= '0;
      {scan_q, astop_q}      <= '0;
    end else begin
      if (wr0) {ie_q, cks_q, chsel_q} <= {bus_wdata[6], bus_wdata[4], bus_wdata[3:0]};
      if (wr1 && !start_q) {astop_q, scan_q} <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      busy_q     <= 1'b0;
      cur_ch_q   <= '0;
      set_pend_q <= 1'b0;
    end else begin
      if (wr0)           start_q <= bus_wdata[5];
      else if (auto_clr) start_q <= 1'b0;

      if (wr0 && !bus_wdata[5]) busy_q <= 1'b0;
      else if (conv_start)      busy_q <= 1'b1;
      else if (done_ok)         busy_q <= 1'b0;

      if (wr0 && bus_wdata[5] && !start_q)
        cur_ch_q <= scan_q ? 4'd0 : bus_wdata[3:0];
      else if (done_ok && scan_q)
        cur_ch_q <= last_ch ? 4'd0 : cur_ch_q + 4'd1;

      set_pend_q <= fin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      rd_seen_q <= 1'b0;
    end else begin
      if (set_pend_q)   flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;

      if (clr_req && !set_pend_q)           rd_seen_q <= 1'b0;
      else if (bus_rd && !bus_addr && flag_q) rd_seen_q <= 1'b1;
    end
  end
endmodule

module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       res_rd,
  input logic       dma_ack,
  input logic       conv_start,
  input logic       start_q,
  input logic       flag_q,
  input logic       rd_seen_q,
  input logic       scan_q,
  input logic       astop_q
);
  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  flag_after_autostop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_q) && !$past(bus_wr && !bus_addr)) |=> flag_q);

  // R12
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> ($stable(scan_q) && $stable(astop_q)));

  // R9
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past((bus_wr && !bus_addr && !bus_wdata[7] && rd_seen_q)
                            || (res_rd && dma_ack)));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .res_rd(res_rd), .dma_ack(dma_ack),
  .conv_start(conv_start), .start_q(start_q), .flag_q(flag_q),
  .rd_seen_q(rd_seen_q), .scan_q(scan_q), .astop_q(astop_q)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic       clk = 0, rst_n = 0;
  logic       bus_addr = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       res_rd = 0, dma_ack = 0;
  logic       conv_start, conv_done = 0, irq;
  logic [3:0] conv_ch;

  int n_chk = 0, n_fail = 0;
  int log_n = 0;
  logic [3:0] log_ch [64];
  int cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .res_rd(res_rd), .dma_ack(dma_ack), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .irq(irq)
  );

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (cnt != 0) begin
      cnt = cnt - 1;
      if (cnt == 0) conv_done = 1'b1;
    end
    if (conv_start && rst_n) begin
      if (log_n < 64) log_ch[log_n] = conv_ch;
      log_n = log_n + 1;
      cnt = LAT;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    step();
    bus_wr = 0; bus_addr = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    step();
    bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    step();
    bus_rd = 0; bus_addr = 0;
  endtask

  task automatic rd_clear();
    logic [7:0] v;
    rd(0, v);
    wr(0, 8'h00);
  endtask

  function automatic logic [7:0] r0();
    return u_adc_seq_ctrl.bus_rdata;
  endfunction

  task automatic wait_done();
    for (int i = 0; i < 50 && !conv_done; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1
    bus_addr = 0; #1 chk("R1 reg0", bus_rdata, 0);
    bus_addr = 1; #1 chk("R1 reg1", bus_rdata, 0);
    bus_addr = 0;
    chk("R1 irq", irq, 0);
    chk("R1 conv_start", conv_start, 0);

    // R2 layout
    wr(0, 8'h5A); rd(0, v); chk("R2 reg0 readback", v, 8'h5A);
    wr(1, 8'hFE); rd(1, v); chk("R2 reg1 readback", v, 8'h02);
    wr(1, 8'h00); wr(0, 8'h00);
    // R8 write 1 to idle flag
    wr(0, 8'h80); rd(0, v); chk("R8 flag write1 idle", v[7], 0);
    wr(0, 8'h00);

    // R3 single mode sweep, R10/R9 clears, R11 irq
    for (int ch = 0; ch < 16; ch++) begin
      logic ie;
      ie = ch[1];
      log_n = 0;
      wr(0, {1'b0, ie, 1'b1, 1'b0, ch[3:0]});
      wait_done();
      chk("R3 start still set at done", r0()[5], 1);
      step();
      chk("R3 start cleared after done", r0()[5], 0);
      chk("R3 flag not yet set", r0()[7], 0);
      step();
      chk("R3 flag set", r0()[7], 1);
      chk("R11 irq", irq, ie);
      chk("R13 one conversion", log_n, 1);
      chk("R3 channel", log_ch[0], ch);
      if (ch[0]) begin
        step(); res_rd = 1; dma_ack = 1; step(); res_rd = 0; dma_ack = 0;
        chk("R10 dma clear", r0()[7], 0);
      end else begin
        rd_clear();
        chk("R9 read then write0 clears", r0()[7], 0);
      end
      chk("R11 irq low after clear", irq, 0);
    end

    // R5 scan with auto-stop, R4 order
    wr(1, 8'h03);
    for (int n = 0; n < 16; n++) begin
      log_n = 0;
      wr(0, {4'b0010, n[3:0]});
      for (int i = 0; i < 300 && r0()[5]; i++) step();
      chk("R5 flag clear when start falls", r0()[7], 0);
      step();
      chk("R5 flag set after start falls", r0()[7], 1);
      chk("R4 conversion count", log_n, n + 1);
      for (int i = 0; i <= n; i++) chk("R4 ascending order", log_ch[i], i);
      rd_clear();
    end

    // R6 continuous scan over 0..2
    wr(1, 8'h01);
    log_n = 0;
    wr(0, 8'h22);
    for (int i = 0; i < 300 && log_n < 8; i++) step();
    chk("R6 start stays set", r0()[5], 1);
    chk("R6 flag after first pass", r0()[7], 1);
    for (int i = 0; i < 8; i++) chk("R4 wrap order", log_ch[i], i % 3);
    // R12
    wr(1, 8'h02); rd(1, v); chk("R12 mode write ignored", v, 8'h01);
    // R7 stop
    wr(0, 8'h02);
    base = log_n;
    repeat (20) step();
    chk("R7 no conversions after stop", log_n, base);
    chk("R7 start clear", r0()[5], 0);
    // R8 write 0 without prior read
    chk("R8 flag kept without read", r0()[7], 1);
    rd(0, v);
    wr(0, 8'h80);
    chk("R8 write 1 no effect", r0()[7], 1);
    step(); res_rd = 1; dma_ack = 0; step(); res_rd = 0;
    chk("R10 plain result read keeps flag", r0()[7], 1);
    wr(0, 8'h00);
    chk("R9 clear after earlier read", r0()[7], 0);
    wr(1, 8'h02); rd(1, v); chk("R12 mode write when idle", v, 8'h02);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule